// File: doc/BRIEF.md
# JTAG Scan Master with Masked Compare

This block is a host-side engine that drives the four test pins of a JTAG chain (clock, mode select, data out to the chain) and samples the data returned from the chain. It accepts one command at a time: a chain reset, a run of idle clocks, or a complete instruction-register or data-register scan. It walks the TAP through the required states by itself and tracks the TAP state internally. For scans it shifts the supplied word out while it captures the returned bits, and it compares the returned bits with an expected value under a mask.

Each command ends with a one-cycle done pulse. The pulse carries the captured word, right-aligned, and a mismatch flag. The test clock is made by dividing the system clock. Its half period is a run-time count of system clocks. Between commands the test clock rests low. Scan and idle commands assume that the TAP is in RUN-TEST/IDLE, which is where a reset command leaves it.

Top module: `jtag_scan_master`

## Requirements
- R1: Command code 0 (reset) produces exactly 6 TCK rising edges: TMS is high for the first 5 and low for the last. Afterwards tap_state reads 1 (RUN-TEST/IDLE). tap_state codes: 0 TEST-LOGIC-RESET, 1 RUN-TEST/IDLE, 2 to 8 the DR column (select, capture, shift, exit1, pause, exit2, update), 9 to 15 the IR column in the same order.
- R2: TMS and TDI change only while TCK is low, so both are stable around every TCK rising edge.
- R3: A DR scan (code 3) of L bits uses 3+L+2 TCK rising edges, and an IR scan (code 2) uses 4+L+2. The IR scan passes through both select states. The last data bit is shifted with TMS high, then comes UPDATE, and the scan ends in RUN-TEST/IDLE.
- R4: Data leaves on TDI least significant bit first. TDO is sampled on each TCK rising edge in the shift state. The captured bits are returned right-aligned in done_tdo, with zeros above bit L-1.
- R5: done_mismatch is set when any bit position below L differs between the captured word and the expected word, where that position is also set in the mask. Expected and mask bits at positions L and above are ignored.
- R6: Command code 1 (idle) with count N produces N TCK rising edges with TMS low and leaves the TAP in RUN-TEST/IDLE. N=0 completes with no TCK edge.
- R7: cmd_ready is high only while no command is running. A command is taken on cmd_valid and cmd_ready, and cmd_ready then drops. done is a one-cycle pulse, and done_tdo and done_mismatch hold their values until the next done. After reset cmd_ready is 1, done is 0 and tap_state is 0.
- R8: TCK stays high and low for half_period system clocks each, and a value of 0 counts as 1. TCK is low whenever no command runs.
- R9: A scan length of 0 is run as 1 bit, and a length above the data width is run as the full data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | HP_W | TCK half period in system clocks (0 counts as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine free to accept a command |
| cmd_op | input | 2 | 0 reset, 1 idle, 2 IR scan, 3 DR scan |
| cmd_len | input | LEN_W | Scan length in bits |
| cmd_count | input | CNT_W | Idle TCK count |
| cmd_tdi | input | DW | Word shifted out, LSB first |
| cmd_expect | input | DW | Expected captured word |
| cmd_mask | input | DW | Compare mask, 1 = compare |
| done | output | 1 | Command complete pulse |
| done_tdo | output | DW | Captured word, right-aligned |
| done_mismatch | output | 1 | Masked compare failed |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Data toward the chain |
| tdo | input | 1 | Data from the chain |
| tap_state | output | 4 | Tracked TAP state |

## Verification
The bench builds the block with its default parameters: 32-bit data, an 8-bit half-period field and a 16-bit idle count. The 32-bit width is what lets a full identification word be captured and masked, and the clamp above the data width is reachable at that size. At run time the half period is driven as 0, 1 and 3, which exercises the minimum clamp and a multi-cycle phase. The target model behind the pins has an 8-bit instruction register, a 32-bit identification register, a bypass bit and a 16-bit scratch register. These give scans of 1, 8, 16 and 32 bits, a one-bit shift delay through bypass, and write-then-read data.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  typedef enum logic [3:0] {
    TAP_TLR = 4'd0,  TAP_RTI = 4'd1,
    TAP_SDR = 4'd2,  TAP_CDR = 4'd3,  TAP_SHDR = 4'd4, TAP_E1DR = 4'd5,
    TAP_PDR = 4'd6,  TAP_E2DR = 4'd7, TAP_UDR = 4'd8,
    TAP_SIR = 4'd9,  TAP_CIR = 4'd10, TAP_SHIR = 4'd11, TAP_E1IR = 4'd12,
    TAP_PIR = 4'd13, TAP_E2IR = 4'd14, TAP_UIR = 4'd15
  } tap_st_e;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0, OP_IDLE = 2'd1, OP_SCAN_IR = 2'd2, OP_SCAN_DR = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RST, PH_WAIT, PH_PRE, PH_SHIFT, PH_POST, PH_END
  } phase_e;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      TAP_TLR:  tap_next = m ? TAP_TLR  : TAP_RTI;
      TAP_RTI:  tap_next = m ? TAP_SDR  : TAP_RTI;
      TAP_SDR:  tap_next = m ? TAP_SIR  : TAP_CDR;
      TAP_CDR:  tap_next = m ? TAP_E1DR : TAP_SHDR;
      TAP_SHDR: tap_next = m ? TAP_E1DR : TAP_SHDR;
      TAP_E1DR: tap_next = m ? TAP_UDR  : TAP_PDR;
      TAP_PDR:  tap_next = m ? TAP_E2DR : TAP_PDR;
      TAP_E2DR: tap_next = m ? TAP_UDR  : TAP_SHDR;
      TAP_UDR:  tap_next = m ? TAP_SDR  : TAP_RTI;
      TAP_SIR:  tap_next = m ? TAP_TLR  : TAP_CIR;
      TAP_CIR:  tap_next = m ? TAP_E1IR : TAP_SHIR;
      TAP_SHIR: tap_next = m ? TAP_E1IR : TAP_SHIR;
      TAP_E1IR: tap_next = m ? TAP_UIR  : TAP_PIR;
      TAP_PIR:  tap_next = m ? TAP_E2IR : TAP_PIR;
      TAP_E2IR: tap_next = m ? TAP_UIR  : TAP_SHIR;
      default:  tap_next = m ? TAP_SDR  : TAP_RTI;
    endcase
  endfunction

endpackage

// File: rtl/jscan_tck_gen.sv
module jscan_tck_gen #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [HP_W-1:0] half_i,
  output logic            tck_o,
  output logic            rise_o,
  output logic            fall_o
);

  logic [HP_W-1:0] cnt_q, cnt_d, hp_eff;
  logic            tck_q, tck_d, active, wrap;

  always_comb begin
    hp_eff = (half_i == '0) ? HP_W'(1) : half_i;
    active = en_i | tck_q;
    wrap   = active && (cnt_q >= hp_eff - HP_W'(1));
    cnt_d  = (!active || wrap) ? '0 : cnt_q + HP_W'(1);
    tck_d  = wrap ? ~tck_q : tck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_q <= tck_d;
    end
  end

  assign tck_o  = tck_q;
  assign rise_o = wrap & ~tck_q;
  assign fall_o = wrap & tck_q;

  AST_TCK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !tck_q) |=> !tck_q); // R8

endmodule

// File: rtl/jscan_tap_track.sv
module jscan_tap_track
  import jscan_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step_i,
  input  logic    tms_i,
  output tap_st_e state_o
);

  tap_st_e    st_q, st_d;
  logic [2:0] ones_q, ones_d;

  always_comb begin
    st_d   = st_q;
    ones_d = ones_q;
    if (step_i) begin
      st_d   = tap_next(st_q, tms_i);
      ones_d = !tms_i ? 3'd0 : (ones_q == 3'd5) ? 3'd5 : ones_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TAP_TLR;
      ones_q <= 3'd0;
    end else begin
      st_q   <= st_d;
      ones_q <= ones_d;
    end
  end

  assign state_o = st_q;

  AST_FIVE_HIGH_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q == 3'd5) |-> (st_q == TAP_TLR)); // R1

endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
  import jscan_pkg::*;
#(
  parameter int DW      = 32,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  op_e              op_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DW-1:0]    tdi_word_i,
  input  logic [DW-1:0]    expect_i,
  input  logic [DW-1:0]    mask_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tck_i,
  input  logic             tdo_i,
  output logic             en_o,
  output logic             tms_o,
  output logic             tdi_o,
  output logic             sample_o,
  output logic             done_o,
  output logic [DW-1:0]    data_o,
  output logic             mismatch_o
);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic [LEN_W-1:0] len_q, len_d, len_eff;
  logic             st_q, st_d, ir_q, ir_d;
  logic [DW-1:0]    sh_q, sh_d, cap_q, cap_d, exp_q, exp_d, msk_q, msk_d;
  logic [DW-1:0]    data_q, data_d, aligned, lmask;
  logic             tms_q, tms_d, tdi_q, tdi_d, done_q, done_d, mis_q, mis_d;
  logic             cur_tms, cur_tdi, running, last_shift;

  always_comb begin
    if (len_i == '0)                len_eff = LEN_W'(1);
    else if (len_i > LEN_W'(DW))    len_eff = LEN_W'(DW);
    else                            len_eff = len_i;
    last_shift = (cnt_q == CNT_W'(len_q) - CNT_W'(1));
    running    = (ph_q == PH_RST) || (ph_q == PH_WAIT) || (ph_q == PH_PRE) ||
                 (ph_q == PH_SHIFT) || (ph_q == PH_POST);
    case (ph_q)
      PH_RST:   cur_tms = cnt_q < CNT_W'(RST_CYC);
      PH_WAIT:  cur_tms = 1'b0;
      PH_PRE:   cur_tms = cnt_q < (ir_q ? CNT_W'(2) : CNT_W'(1));
      PH_SHIFT: cur_tms = last_shift;
      PH_POST:  cur_tms = (cnt_q == '0);
      default:  cur_tms = tms_q;
    endcase
    cur_tdi = (ph_q == PH_SHIFT) ? sh_q[0] : 1'b0;
    aligned = cap_q >> (LEN_W'(DW) - len_q);
    lmask   = (DW'(1) << len_q) - DW'(1);
  end

  always_comb begin
    ph_d = ph_q;  cnt_d = cnt_q;  lim_d = lim_q;  len_d = len_q;
    st_d = st_q;  ir_d = ir_q;    sh_d = sh_q;    cap_d = cap_q;
    exp_d = exp_q; msk_d = msk_q; tms_d = tms_q;  tdi_d = tdi_q;
    data_d = data_q; mis_d = mis_q; done_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (cmd_valid_i) begin
          cnt_d = '0;  st_d = 1'b1;  cap_d = '0;
          len_d = LEN_W'(1);  exp_d = '0;  msk_d = '0;  sh_d = '0;
          ir_d  = (op_i == OP_SCAN_IR);
          case (op_i)
            OP_RESET: ph_d = PH_RST;
            OP_IDLE: begin
              lim_d = count_i;
              if (count_i == '0) begin
                ph_d = PH_END;
                st_d = 1'b0;
              end else begin
                ph_d = PH_WAIT;
              end
            end
            default: begin
              ph_d  = PH_PRE;
              len_d = len_eff;
              sh_d  = tdi_word_i;
              exp_d = expect_i;
              msk_d = mask_i;
            end
          endcase
        end
      end
      PH_END: begin
        if (!tck_i) begin
          done_d = 1'b1;
          data_d = aligned;
          mis_d  = |((aligned ^ exp_q) & msk_q & lmask);
          ph_d   = PH_IDLE;
        end
      end
      default: begin
        if (st_q) begin
          st_d  = 1'b0;
          tms_d = cur_tms;
          tdi_d = cur_tdi;
        end else if (rise_i) begin
          cnt_d = cnt_q + CNT_W'(1);
          case (ph_q)
            PH_RST:  if (cnt_q == CNT_W'(RST_CYC)) ph_d = PH_END;
            PH_WAIT: if (cnt_q == lim_q - CNT_W'(1)) ph_d = PH_END;
            PH_PRE: begin
              if (cnt_q == (ir_q ? CNT_W'(3) : CNT_W'(2))) begin
                ph_d  = PH_SHIFT;
                cnt_d = '0;
              end
            end
            PH_SHIFT: begin
              cap_d = {tdo_i, cap_q[DW-1:1]};
              sh_d  = sh_q >> 1;
              if (last_shift) begin
                ph_d  = PH_POST;
                cnt_d = '0;
              end
            end
            default: if (cnt_q == CNT_W'(1)) ph_d = PH_END;
          endcase
        end else if (fall_i) begin
          tms_d = cur_tms;
          tdi_d = cur_tdi;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;  cnt_q <= '0;  lim_q <= '0;  len_q <= LEN_W'(1);
      st_q <= 1'b0;     ir_q <= 1'b0; sh_q <= '0;   cap_q <= '0;
      exp_q <= '0;      msk_q <= '0;  tms_q <= 1'b0; tdi_q <= 1'b0;
      data_q <= '0;     mis_q <= 1'b0; done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;     cnt_q <= cnt_d; lim_q <= lim_d; len_q <= len_d;
      st_q <= st_d;     ir_q <= ir_d;   sh_q <= sh_d;   cap_q <= cap_d;
      exp_q <= exp_d;   msk_q <= msk_d; tms_q <= tms_d; tdi_q <= tdi_d;
      data_q <= data_d; mis_q <= mis_d; done_q <= done_d;
    end
  end

  assign cmd_ready_o = (ph_q == PH_IDLE);
  assign en_o        = running && !st_q;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;
  assign sample_o    = rise_i && (ph_q == PH_SHIFT) && !st_q;
  assign done_o      = done_q;
  assign data_o      = data_q;
  assign mismatch_o  = mis_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o); // R7
  AST_DONE_WITH_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !tck_i); // R8

endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
  import jscan_pkg::*;
#(
  parameter int DW      = 32,
  parameter int HP_W    = 8,
  parameter int CNT_W   = 16,
  parameter int RST_CYC = 5,
  localparam int LEN_W  = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HP_W-1:0]  half_period,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [DW-1:0]    cmd_tdi,
  input  logic [DW-1:0]    cmd_expect,
  input  logic [DW-1:0]    cmd_mask,
  output logic             done,
  output logic [DW-1:0]    done_tdo,
  output logic             done_mismatch,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic [3:0]       tap_state
);

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       en, rise, fall, sample;
  tap_st_e    st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  jscan_tck_gen #(.HP_W(HP_W)) u_tck (
    .clk(clk), .rst_n(rst_s), .en_i(en), .half_i(half_period),
    .tck_o(tck), .rise_o(rise), .fall_o(fall)
  );

  jscan_seq #(.DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_seq (
    .clk(clk), .rst_n(rst_s), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .op_i(op_e'(cmd_op)), .len_i(cmd_len), .count_i(cmd_count),
    .tdi_word_i(cmd_tdi), .expect_i(cmd_expect), .mask_i(cmd_mask),
    .rise_i(rise), .fall_i(fall), .tck_i(tck), .tdo_i(tdo),
    .en_o(en), .tms_o(tms), .tdi_o(tdi), .sample_o(sample),
    .done_o(done), .data_o(done_tdo), .mismatch_o(done_mismatch)
  );

  jscan_tap_track u_trk (
    .clk(clk), .rst_n(rst_s), .step_i(rise), .tms_i(tms), .state_o(st)
  );

  assign tap_state = st;

  AST_PINS_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_s)
    (!$stable(tms) || !$stable(tdi)) |-> !tck); // R2
  AST_SAMPLE_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_s)
    sample |-> (st == TAP_SHDR || st == TAP_SHIR)); // R3

endmodule

// File: tb/tb_jtag_scan_master.sv
module tb_jtag_scan_master;

  localparam int DW = 32;
  localparam int HP_W = 8;
  localparam int CNT_W = 16;
  localparam int LEN_W = 6;

  logic             clk, rst_n, cmd_valid, cmd_ready, done, done_mismatch;
  logic [HP_W-1:0]  half_period;
  logic [1:0]       cmd_op;
  logic [LEN_W-1:0] cmd_len;
  logic [CNT_W-1:0] cmd_count;
  logic [DW-1:0]    cmd_tdi, cmd_expect, cmd_mask, done_tdo;
  logic             tck, tms, tdi, tdo;
  logic [3:0]       tap_state;

  int errors = 0;
  int checks = 0;

  jtag_scan_master dut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_len(cmd_len), .cmd_count(cmd_count), .cmd_tdi(cmd_tdi),
    .cmd_expect(cmd_expect), .cmd_mask(cmd_mask), .done(done),
    .done_tdo(done_tdo), .done_mismatch(done_mismatch),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tap_state(tap_state)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- target model on the pins ----------------
  int          t_st = 0;
  logic [7:0]  t_ir = 8'h01, t_irsr = 8'h00;
  logic [31:0] t_idsr = 32'h0;
  logic        t_byp = 1'b0;
  logic [15:0] t_scr = 16'h1234, t_scrsr = 16'h0;
  int          rises = 0;

  function automatic int t_next(int s, logic m);
    case (s)
      0: return m ? 0 : 1;    1: return m ? 2 : 1;
      2: return m ? 9 : 3;    3: return m ? 5 : 4;
      4: return m ? 5 : 4;    5: return m ? 8 : 6;
      6: return m ? 7 : 6;    7: return m ? 8 : 4;
      8: return m ? 2 : 1;    9: return m ? 0 : 10;
      10: return m ? 12 : 11; 11: return m ? 12 : 11;
      12: return m ? 15 : 13; 13: return m ? 14 : 13;
      14: return m ? 15 : 11; default: return m ? 2 : 1;
    endcase
  endfunction

  always @(posedge tck) begin
    rises <= rises + 1;
    case (t_st)
      0:  begin t_ir <= 8'h01; t_scr <= 16'h1234; end
      10: t_irsr <= 8'h25;
      11: t_irsr <= {tdi, t_irsr[7:1]};
      15: t_ir <= t_irsr;
      3:  begin t_idsr <= 32'h16e5e093; t_byp <= 1'b0; t_scrsr <= t_scr; end
      4: begin
        if (t_ir == 8'h01)      t_idsr  <= {tdi, t_idsr[31:1]};
        else if (t_ir == 8'h02) t_scrsr <= {tdi, t_scrsr[15:1]};
        else                    t_byp   <= tdi;
      end
      8:  if (t_ir == 8'h02) t_scr <= t_scrsr;
      default: ;
    endcase
    t_st <= t_next(t_st, tms);
  end

  always @(negedge tck or negedge rst_n) begin
    if (!rst_n)             tdo <= 1'b0;
    else if (t_st == 11)    tdo <= t_irsr[0];
    else if (t_st == 4)     tdo <= (t_ir == 8'h01) ? t_idsr[0] :
                                   (t_ir == 8'h02) ? t_scrsr[0] : t_byp;
    else                    tdo <= 1'b0;
  end

  // ---------------- pin monitors ----------------
  int   pin_viol = 0;
  int   hi_run = 0, last_hi = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0;
  always @(negedge clk) begin
    if (rst_n && tck && p_tck && (tms !== p_tms || tdi !== p_tdi)) pin_viol++;
    p_tck = tck; p_tms = tms; p_tdi = tdi;
    if (tck) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] r_data;
  logic        r_mis;
  int          r_rises;

  task automatic run_cmd(input logic [1:0] op, input logic [LEN_W-1:0] len,
                         input logic [CNT_W-1:0] cnt, input logic [31:0] wd,
                         input logic [31:0] ex, input logic [31:0] mk);
    int r0;
    @(negedge clk);
    cmd_op = op; cmd_len = len; cmd_count = cnt;
    cmd_tdi = wd; cmd_expect = ex; cmd_mask = mk; cmd_valid = 1'b1;
    r0 = rises;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!done) chk(cmd_ready == 1'b0, "R7 ready low while busy", 32'(cmd_ready), 32'd0);
    while (!done) @(negedge clk);
    r_data = done_tdo; r_mis = done_mismatch; r_rises = rises - r0;
    @(negedge clk);
    chk(done == 1'b0, "R7 done is one cycle", 32'(done), 32'd0);
    chk(done_tdo == r_data, "R7 done_tdo held", done_tdo, r_data);
  endtask

  task automatic t_reset_state();
    chk(cmd_ready == 1'b1, "R7 ready after reset", 32'(cmd_ready), 32'd1);
    chk(done == 1'b0, "R7 done after reset", 32'(done), 32'd0);
    chk(tap_state == 4'd0, "R7 tap_state after reset", 32'(tap_state), 32'd0);
    chk(tck == 1'b0, "R8 tck low after reset", 32'(tck), 32'd0);
  endtask

  task automatic t_chain_reset();
    half_period = 8'd1;
    run_cmd(2'd0, '0, '0, '0, '0, '0);
    chk(r_rises == 6, "R1 reset edge count", 32'(r_rises), 32'd6);
    chk(tap_state == 4'd1, "R1 ends in run-test/idle", 32'(tap_state), 32'd1);
    chk(t_st == 1, "R1 target in run-test/idle", 32'(t_st), 32'd1);
  endtask

  task automatic t_ir_scan();
    run_cmd(2'd2, 6'd8, '0, 32'h01, 32'h25, 32'h03);
    chk(r_data == 32'h25, "R4 IR capture", r_data, 32'h25);
    chk(r_mis == 1'b0, "R5 IR masked pass", 32'(r_mis), 32'd0);
    chk(r_rises == 14, "R3 IR edge count", 32'(r_rises), 32'd14);
    chk(tap_state == 4'd1 && t_st == 1, "R3 IR ends idle", 32'(tap_state), 32'd1);
    chk(t_ir == 8'h01, "R4 IR loaded LSB first", 32'(t_ir), 32'h01);
  endtask

  task automatic t_id_scan();
    half_period = 8'd3;
    run_cmd(2'd3, 6'd32, '0, 32'h0, 32'hf6e5f093, 32'h0fff8fff);
    chk(r_data == 32'h16e5e093, "R4 DR capture", r_data, 32'h16e5e093);
    chk(r_mis == 1'b0, "R5 DR masked pass", 32'(r_mis), 32'd0);
    chk(r_rises == 37, "R3 DR edge count", 32'(r_rises), 32'd37);
    chk(last_hi == 3, "R8 half period 3", 32'(last_hi), 32'd3);
    run_cmd(2'd3, 6'd32, '0, 32'h0, 32'h0, 32'h1);
    chk(r_mis == 1'b1, "R5 DR masked fail", 32'(r_mis), 32'd1);
    run_cmd(2'd2, 6'd8, '0, 32'h01, 32'h00, 32'h03);
    chk(r_mis == 1'b1, "R5 IR masked fail", 32'(r_mis), 32'd1);
  endtask

  task automatic t_bypass();
    half_period = 8'd1;
    run_cmd(2'd2, 6'd8, '0, 32'hFF, 32'h0, 32'h0);
    run_cmd(2'd3, 6'd8, '0, 32'hB4, 32'h0, 32'h0);
    chk(r_data == 32'h68, "R4 bypass one-bit delay", r_data, 32'h68);
    chk(r_rises == 13, "R3 short DR edge count", 32'(r_rises), 32'd13);
  endtask

  task automatic t_scratch();
    run_cmd(2'd2, 6'd8, '0, 32'h02, 32'h0, 32'h0);
    run_cmd(2'd3, 6'd16, '0, 32'hBEEF, 32'h0, 32'h0);
    chk(r_data == 32'h1234, "R4 scratch initial", r_data, 32'h1234);
    run_cmd(2'd3, 6'd16, '0, 32'h0, 32'hFFFFBEEF, 32'hFFFFFFFF);
    chk(r_data == 32'hBEEF, "R4 scratch readback", r_data, 32'hBEEF);
    chk(r_mis == 1'b0, "R5 bits above length ignored", 32'(r_mis), 32'd0);
  endtask

  task automatic t_idle();
    half_period = 8'd0;
    run_cmd(2'd1, '0, 16'd7, '0, '0, '0);
    chk(r_rises == 7, "R6 idle edge count", 32'(r_rises), 32'd7);
    chk(tap_state == 4'd1 && t_st == 1, "R6 idle stays idle", 32'(tap_state), 32'd1);
    chk(last_hi == 1, "R8 half period zero as one", 32'(last_hi), 32'd1);
    run_cmd(2'd1, '0, 16'd0, '0, '0, '0);
    chk(r_rises == 0, "R6 idle zero count", 32'(r_rises), 32'd0);
  endtask

  task automatic t_len_clamp();
    half_period = 8'd1;
    run_cmd(2'd3, 6'd0, '0, 32'h1, 32'h0, 32'h0);
    chk(r_rises == 6, "R9 zero length runs one bit", 32'(r_rises), 32'd6);
    chk(r_data == 32'h0, "R9 one-bit capture", r_data, 32'h0);
    run_cmd(2'd2, 6'd8, '0, 32'h01, 32'h0, 32'h0);
    run_cmd(2'd3, 6'd40, '0, 32'h0, 32'h0, 32'h0);
    chk(r_rises == 37, "R9 long length clamped", 32'(r_rises), 32'd37);
    chk(r_data == 32'h16e5e093, "R9 clamped capture", r_data, 32'h16e5e093);
    chk(pin_viol == 0, "R2 pins stable while tck high", 32'(pin_viol), 32'd0);
    chk(tck == 1'b0, "R8 tck rests low", 32'(tck), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_len = '0; cmd_count = '0;
    cmd_tdi = '0; cmd_expect = '0; cmd_mask = '0; half_period = 8'd1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_chain_reset();
    t_ir_scan();
    t_id_scan();
    t_bypass();
    t_scratch();
    t_idle();
    t_len_clamp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule